// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. It accepts a new read or write on every enabled clock edge and never needs an idle cycle when switching between the two. Every control, address and byte-lane input is captured on the rising edge. Read data comes out of an output register. Write data follows its address by two enabled edges, which is the same distance a read takes to return data. This matching delay is what lets reads and writes interleave without any gap on the data side.

A short burst engine can continue an access through a group of four neighbouring addresses. It runs in linear or interleaved order. A three-input chip-select decode gates the start of each access. An active-low clock enable freezes the whole pipeline. An output-enable input controls whether the read bus is driven. Writes that have not yet reached the array are forwarded to a read of the same word that follows right behind them, one lane at a time, so the read never returns stale contents.

Top module: `zbt_sram`

## Requirements
- R1: The device is selected only when cs1_n=0, cs2=1 and cs3_n=0. A load edge with any other combination starts no access. It writes nothing to the array and never raises rdata_en.
- R2: Data for a read sampled at enabled edge N appears on rdata after enabled edge N+2. rdata_en is high only while oe_n is low. With oe_n high, rdata_en is low and rdata is zero.
- R3: A write sampled at enabled edge N takes its data from wdata at enabled edge N+2. Lane i covers bits 8i+7:8i. It is written when lane_wr_n[i] was 0 at edge N, and keeps its old contents when that bit was 1.
- R4: Reads and writes may alternate on consecutive enabled edges with no idle cycles, and each one returns or stores the correct data.
- R5: A read sampled one enabled edge after a write to the same address returns that write's data in the enabled lanes and the older array contents in the others.
- R6: While clk_en_n is 1, an edge changes nothing. The output data and rdata_en hold, no write is performed, and pending operations complete only after further enabled edges.
- R7: With lin_order=1, the k-th access of a burst (k=0..3) uses low address bits (start+k) mod 4. The upper address bits stay those of the load address.
- R8: With lin_order=0, the k-th access of a burst uses low address bits start XOR k. The upper address bits stay unchanged.
- R9: An advance edge (adv=1) that follows a deselect continues the deselect, whatever the chip selects and wr_n show.
- R10: While rst_n is low, rdata_en is 0 and the pipeline holds no pending access.
- R11: An advance edge after a read or write continues the same kind of access at the next burst address. It ignores the chip selects and wr_n, but samples lane_wr_n again on each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the edge |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| cs3_n | input | 1 | Active-low chip select |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr_n | input | 1 | 0 = write, 1 = read, on a load edge |
| lane_wr_n | input | LANES | Active-low byte-lane write selects |
| addr | input | ADDR_W | Word address, used on a load edge |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| wdata | input | LANES*LANE_W | Write data, two enabled edges after its address |
| oe_n | input | 1 | Active-low output enable |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_en | output | 1 | High when rdata is driven |

## Verification
The bench attacks the write-then-read-same-address case, including a single-lane write. A design without forwarding there returns the old word, and one that forwards whole words instead of merging lanes corrupts the untouched byte. It runs bursts in both orders from a start address in the middle of a group of four. A wrong counter would carry into the upper bits or visit the addresses in the wrong order, and the readback would show it. Stall edges are inserted both under an outstanding read and under a pending write. A design that lets a stall move the pipeline would show a changed output or return data one edge early. Finally, advance edges after a deselect and loads with each chip select wrong confirm that nothing starts or gets written.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low two address bits for the k-th beat of a burst.
    function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                             input logic [1:0] k,
                                             input logic       lin);
        logic [1:0] r;
        if (lin) r = start + k;
        else     r = start ^ k;
        return r;
    endfunction

endpackage

// File: rtl/zbt_burst.sv
module zbt_burst #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load_i,
    input  logic          lin_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    import zbt_pkg::*;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            addr_o = addr_i;
        end else begin
            addr_o = {st_q.base[AW-1:2], burst_lsb(st_q.base[1:0], st_q.cnt, lin_i)};
        end
        if (en) begin
            if (load_i) begin
                st_d.base = addr_i;
                st_d.cnt  = 2'd1;
            end else begin
                st_d.cnt  = st_q.cnt + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Advancing never carries into the upper address bits.
    assert_wrap_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load_i) |=> (load_i || addr_o[AW-1:2] == $past(addr_o[AW-1:2])));

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int AW = 6,
    parameter int NL = 2,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [NL-1:0]    wbe,
    input  logic [NL*LW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NL*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wbe[g]) mem[waddr] <= wdata[g*LW +: LW];
        end
        assign rdata[g*LW +: LW] = mem[raddr];
    end

endmodule

// File: rtl/zbt_fwd.sv
module zbt_fwd #(
    parameter int NL = 2,
    parameter int LW = 8
) (
    input  logic             hit,
    input  logic [NL-1:0]    wbe,
    input  logic [NL*LW-1:0] arr_data,
    input  logic [NL*LW-1:0] wdata,
    output logic [NL*LW-1:0] data_o
);
    for (genvar g = 0; g < NL; g++) begin : g_merge
        assign data_o[g*LW +: LW] = (hit && wbe[g]) ? wdata[g*LW +: LW]
                                                    : arr_data[g*LW +: LW];
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en_n,
    input  logic                      cs1_n,
    input  logic                      cs2,
    input  logic                      cs3_n,
    input  logic                      adv,
    input  logic                      wr_n,
    input  logic [LANES-1:0]          lane_wr_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      lin_order,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic                      oe_n,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rdata_en
);
    import zbt_pkg::*;

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] a;
        logic [LANES-1:0]  be;
    } slot_t;

    typedef struct packed {
        op_e               last;
        slot_t             s1;
        slot_t             s2;
        logic [DATA_W-1:0] rd;
        logic              ovld;
        logic [DATA_W-1:0] odat;
    } pipe_t;

    pipe_t p_d, p_q;

    logic              en;
    logic              sel;
    op_e               new_op;
    logic [ADDR_W-1:0] baddr;
    logic              arr_we;
    logic [DATA_W-1:0] arr_rd;
    logic              fwd_hit;
    logic [DATA_W-1:0] fwd_rd;

    assign en  = !clk_en_n;
    assign sel = !cs1_n && cs2 && !cs3_n;

    zbt_burst #(.AW(ADDR_W)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .load_i (!adv),
        .lin_i  (lin_order),
        .addr_i (addr),
        .addr_o (baddr)
    );

    zbt_array #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (p_q.s2.a),
        .wbe   (p_q.s2.be),
        .wdata (wdata),
        .raddr (p_q.s1.a),
        .rdata (arr_rd)
    );

    zbt_fwd #(.NL(LANES), .LW(LANE_W)) u_fwd (
        .hit      (fwd_hit),
        .wbe      (p_q.s2.be),
        .arr_data (arr_rd),
        .wdata    (wdata),
        .data_o   (fwd_rd)
    );

    assign arr_we  = en && (p_q.s2.op == OP_WR);
    assign fwd_hit = (p_q.s2.op == OP_WR) && (p_q.s2.a == p_q.s1.a);

    always_comb begin
        if (adv)       new_op = p_q.last;
        else if (!sel) new_op = OP_NONE;
        else if (wr_n) new_op = OP_RD;
        else           new_op = OP_WR;

        p_d = p_q;
        if (en) begin
            p_d.last  = new_op;
            p_d.s1.op = new_op;
            p_d.s1.a  = baddr;
            p_d.s1.be = ~lane_wr_n;
            p_d.s2    = p_q.s1;
            p_d.rd    = fwd_rd;
            p_d.ovld  = (p_q.s2.op == OP_RD);
            p_d.odat  = p_q.rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rdata_en = p_q.ovld && !oe_n;
    assign rdata    = rdata_en ? p_q.odat : '0;

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(p_q.odat) && $stable(p_q.ovld) && $stable(p_q.s2)));

    assert_pipe_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_n |=> (p_q.s2 == $past(p_q.s1)));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.ovld) |-> ($past(p_q.s2.op) == OP_RD && $past(!clk_en_n)));

    assert_desel_continue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv && p_q.last == OP_NONE) |=> (p_q.s1.op == OP_NONE));

endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

    localparam int CLK_P = 10;
    localparam int NV    = 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        cs1_n = 1'b1;
    logic        cs2 = 1'b1;
    logic        cs3_n = 1'b0;
    logic        adv = 1'b0;
    logic        wr_n = 1'b1;
    logic [1:0]  lane_wr_n = 2'b11;
    logic [5:0]  addr = '0;
    logic        lin_order = 1'b1;
    logic [15:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic [15:0] rdata;
    logic        rdata_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    zbt_sram #(.ADDR_W(6), .LANES(2), .LANE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv(adv), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .lin_order(lin_order), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    typedef struct packed {
        logic        sel;
        logic        adv;
        logic        wr_n;
        logic [1:0]  bw_n;
        logic [5:0]  a;
        logic [15:0] wd;
        logic        lin;
        logic        xen;
        logic [15:0] xd;
    } vec_t;

    // Each row: inputs for one enabled edge, expected output after that edge.
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b0,2'b00,6'h04,16'h0000,1'b1,1'b0,16'h0000}, // 0  W 04
        '{1'b1,1'b0,1'b0,2'b00,6'h05,16'h0000,1'b1,1'b0,16'h0000}, // 1  W 05
        '{1'b1,1'b0,1'b1,2'b00,6'h04,16'hA004,1'b1,1'b0,16'h0000}, // 2  R 04
        '{1'b1,1'b0,1'b1,2'b00,6'h05,16'hB005,1'b1,1'b0,16'h0000}, // 3  R 05
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b1,16'hA004}, // 4
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b1,16'hB005}, // 5
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b0,16'h0000}, // 6
        '{1'b1,1'b0,1'b0,2'b00,6'h09,16'h0000,1'b1,1'b0,16'h0000}, // 7  W 09
        '{1'b1,1'b0,1'b1,2'b00,6'h09,16'h0000,1'b1,1'b0,16'h0000}, // 8  R 09 right behind
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'hC009,1'b1,1'b0,16'h0000}, // 9
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b1,16'hC009}, // 10
        '{1'b1,1'b0,1'b0,2'b01,6'h09,16'h0000,1'b1,1'b0,16'h0000}, // 11 W 09 upper lane
        '{1'b1,1'b0,1'b1,2'b00,6'h09,16'h0000,1'b1,1'b0,16'h0000}, // 12 R 09
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h77FF,1'b1,1'b0,16'h0000}, // 13
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b1,16'h7709}, // 14
        '{1'b1,1'b0,1'b0,2'b00,6'h12,16'h0000,1'b1,1'b0,16'h0000}, // 15 W burst 12 linear
        '{1'b0,1'b1,1'b1,2'b00,6'h00,16'h0000,1'b1,1'b0,16'h0000}, // 16 -> 13
        '{1'b0,1'b1,1'b1,2'b00,6'h00,16'hD012,1'b1,1'b0,16'h0000}, // 17 -> 10
        '{1'b0,1'b1,1'b1,2'b00,6'h00,16'hD013,1'b1,1'b0,16'h0000}, // 18 -> 11
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'hD010,1'b1,1'b0,16'h0000}, // 19
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'hD011,1'b1,1'b0,16'h0000}, // 20
        '{1'b1,1'b0,1'b1,2'b00,6'h13,16'h0000,1'b0,1'b0,16'h0000}, // 21 R burst 13 interleaved
        '{1'b0,1'b1,1'b0,2'b00,6'h00,16'h0000,1'b0,1'b0,16'h0000}, // 22 -> 12
        '{1'b0,1'b1,1'b0,2'b00,6'h00,16'h0000,1'b0,1'b1,16'hD013}, // 23 -> 11
        '{1'b0,1'b1,1'b0,2'b00,6'h00,16'h0000,1'b0,1'b1,16'hD012}, // 24 -> 10
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b1,16'hD011}, // 25 deselect
        '{1'b0,1'b1,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b1,16'hD010}, // 26 advance
        '{1'b1,1'b1,1'b0,2'b00,6'h00,16'h0000,1'b1,1'b0,16'h0000}, // 27 advance
        '{1'b1,1'b1,1'b1,2'b00,6'h00,16'h0000,1'b1,1'b0,16'h0000}, // 28 advance
        '{1'b1,1'b0,1'b0,2'b00,6'h20,16'h0000,1'b1,1'b0,16'h0000}, // 29 W 20
        '{1'b1,1'b0,1'b1,2'b00,6'h09,16'h0000,1'b1,1'b0,16'h0000}, // 30 R 09
        '{1'b1,1'b0,1'b0,2'b00,6'h21,16'hE020,1'b1,1'b0,16'h0000}, // 31 W 21
        '{1'b1,1'b0,1'b1,2'b00,6'h20,16'h0000,1'b1,1'b1,16'h7709}, // 32 R 20
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'hE021,1'b1,1'b0,16'h0000}, // 33
        '{1'b0,1'b0,1'b1,2'b11,6'h00,16'h0000,1'b1,1'b1,16'hE020}  // 34
    };

    function automatic string req_of(input int i);
        if (i <= 6)  return "R3/R2";
        if (i <= 10) return "R5";
        if (i <= 14) return "R5/R3 lane merge";
        if (i <= 20) return "R7/R11";
        if (i <= 26) return "R8/R11";
        if (i <= 30) return "R9";
        return "R4";
    endfunction

    task automatic check(input string req, input logic en_exp, input logic [15:0] d_exp);
        checks++;
        if (rdata_en !== en_exp || (en_exp && rdata !== d_exp) || (!en_exp && rdata !== 16'h0000)) begin
            fails++;
            $display("FAIL %s: got en=%0b data=%h, expected en=%0b data=%h",
                     req, rdata_en, rdata, en_exp, en_exp ? d_exp : 16'h0000);
        end
    endtask

    task automatic edge_step(input logic cen_n, input logic c1n, input logic c2, input logic c3n,
                             input logic a_v, input logic wn, input logic [1:0] bwn,
                             input logic [5:0] ad, input logic [15:0] wd, input logic ln);
        clk_en_n  = cen_n;
        cs1_n     = c1n;
        cs2       = c2;
        cs3_n     = c3n;
        adv       = a_v;
        wr_n      = wn;
        lane_wr_n = bwn;
        addr      = ad;
        wdata     = wd;
        lin_order = ln;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic [15:0] wd);
        edge_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 6'h00, wd, 1'b1);
    endtask

    task automatic rd(input logic [5:0] ad);
        edge_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, ad, 16'h0000, 1'b1);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset", 1'b0, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            edge_step(1'b0, !TBL[i].sel, 1'b1, 1'b0, TBL[i].adv, TBL[i].wr_n,
                      TBL[i].bw_n, TBL[i].a, TBL[i].wd, TBL[i].lin);
            check(req_of(i), TBL[i].xen, TBL[i].xd);
        end

        // R2: output enable gates the bus
        rd(6'h04);
        idle(16'h0000);
        idle(16'h0000);
        check("R2 latency", 1'b1, 16'hA004);
        oe_n = 1'b1;
        #1;
        check("R2 oe_n high", 1'b0, 16'h0000);
        oe_n = 1'b0;
        #1;

        // R6: stall freezes output and in-flight read
        edge_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 6'h05, 16'h0000, 1'b1);
        check("R6 stall hold", 1'b1, 16'hA004);
        rd(6'h05);
        check("R6 read issued", 1'b0, 16'h0000);
        edge_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 6'h00, 16'h0000, 1'b1);
        check("R6 stalled read", 1'b0, 16'h0000);
        idle(16'h0000);
        check("R6 one enabled edge", 1'b0, 16'h0000);
        idle(16'h0000);
        check("R6 read after stall", 1'b1, 16'hB005);

        // R6/R3: stall between write address and write data
        edge_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'h28, 16'h0000, 1'b1);
        idle(16'h0000);
        edge_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 6'h00, 16'hBAD1, 1'b1);
        idle(16'h600D);
        rd(6'h28);
        idle(16'h0000);
        idle(16'h0000);
        check("R6 write data after stall", 1'b1, 16'h600D);

        // R1: deselected loads neither write nor read
        edge_step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'h04, 16'h0000, 1'b1);
        idle(16'h0000);
        idle(16'hFFFF);
        edge_step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 6'h04, 16'h0000, 1'b1);
        idle(16'h0000);
        idle(16'hFFFF);
        edge_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 6'h04, 16'h0000, 1'b1);
        idle(16'h0000);
        idle(16'h0000);
        check("R1 deselected read", 1'b0, 16'h0000);
        rd(6'h04);
        idle(16'h0000);
        idle(16'h0000);
        check("R1 no write while deselected", 1'b1, 16'hA004);

        // R10: reset clears the output
        rst_n = 1'b0;
        #1;
        check("R10 reset mid-run", 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule